// File: doc/BRIEF.md
# SPI Serial NOR Flash Device Model

This block behaves as a small serial NOR flash on an SPI bus in mode 0, so that a flash write sequencer on the same chip or in a bench can be exercised against a target that answers like the real device. The bus pins are oversampled by the system clock. Each chip-select-low period is one frame. The first byte of a frame is the opcode. The model holds a status byte, a small byte array and a busy timer.

It supports the following commands:

- read status, write status and its arming opcode;
- write-enable latch set and clear;
- array read;
- single-byte program;
- burst word program with auto-increment, where only the first frame of the burst carries an address.

Programming can only turn ones into zeros. A whole-array protect field is set at reset, so software must clear it before any program is accepted.

Top module: `flash_model`

## Requirements
- R1: After reset the status byte is 0x1C (protect field bits 4:2 all ones, everything else zero), every array byte reads 0xFF, and MISO is low.
- R2: MOSI is sampled on rising SCK and MISO changes on falling SCK, most significant bit first. Read status (0x05) returns the status byte and repeats it for every further byte while CS_n stays low. MISO is low while CS_n is high.
- R3: Opcode 0x06 sets status bit 1 (write enable). Opcode 0x04 clears bit 1 and bit 6 (burst mode).
- R4: Write status (0x01 followed by one data byte) takes effect only when the frame just before it was the arming opcode 0x50. Otherwise the status byte is unchanged.
- R5: A status write always loads bit 7 (protect lock) from data bit 7. It loads bits 4:2 from data bits 4:2 only when bit 7 was clear before the write.
- R6: While any of status bits 4:2 is set, program commands are ignored: the array is untouched and status bit 1 is kept.
- R7: Byte program (0x02, a 24-bit address sent high byte first, one data byte) needs status bit 1. It stores the old byte ANDed with the data and then clears bit 1.
- R8: The first burst frame (0xAD, 24-bit address, two data bytes) needs bit 1. It ignores address bit 0, writes the even byte and the odd byte after it, sets bit 6 and keeps bit 1.
- R9: While bit 6 is set, a frame of 0xAD plus two data bytes programs the next pair, two addresses above the previous pair.
- R10: An accepted program sets status bit 0 (busy) for BUSY_CYCLES clocks after CS_n rises. A frame whose opcode arrives while busy is ignored, unless it is read status.
- R11: While bit 6 is set, every opcode other than 0xAD, 0x04 and 0x05 is ignored, and a read returns zeros.
- R12: Opcode 0x20 and undefined opcodes change nothing.
- R13: Read (0x03, 24-bit address) returns consecutive bytes. The address wraps modulo DEPTH, and address bits above the array size are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock, idles low (mode 0) |
| cs_n | input | 1 | Active-low chip select; one low period is one frame |
| mosi | input | 1 | Serial data into the model |
| miso | output | 1 | Serial data out of the model, driven low when there is nothing to send |

## Verification
The bench targets the status-write arming rule. It places an unrelated frame between the arming opcode and the write, and a model that remembered the arming too long would accept that write. It also sets the protect lock and then clears it: a model that tested the new lock value instead of the old one would release the protect field in the same write.

For the array, the bench programs the same byte twice to expose a model that overwrites instead of ANDing. It sends a WREN during busy, and a model that ignored busy would leave write enable set. It sends an odd start address to a burst and then an ignored byte program in burst mode. A wrong pointer or a missing mode lock would leave wrong or extra bytes in the array.

Finally, the bench reads across the top of the array, where a model without wrap would return stale data.

// File: rtl/flash_model_pkg.sv
// Package: opcode values and status bit positions shared by the flash model.
// Assumes: one-byte opcodes; status byte layout is fixed by the command set.
package flash_model_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_EWSR  = 8'h50;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_BURST = 8'hAD;
    localparam logic [7:0] OP_ERASE = 8'h20;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;
    localparam int ST_AAI  = 6;
    localparam int ST_BPL  = 7;

    // What MISO is serving in the current frame
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_STATUS = 2'd1,
        TX_ARRAY  = 2'd2
    } tx_mode_e;
endpackage

// File: rtl/fm_spi_frontend.sv
// Module: SPI mode-0 front end. Synchronises SCK, CS_n and MOSI to clk,
// assembles received bytes MSB first on rising SCK, and serialises a
// supplied byte onto MISO on falling SCK.
// Assumes: SCK half period is several clk periods longer than SYNC_STAGES+2.
module fm_spi_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       tx_en,
    input  logic [7:0] tx_byte,
    output logic       byte_vld,
    output logic [7:0] byte_dat,
    output logic [2:0] byte_idx,
    output logic       frame_start,
    output logic       frame_end,
    output logic       tx_next,
    output logic       miso
);
    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES:0]   cs_p;
    logic [SYNC_STAGES-1:0] mosi_p;
    logic sck_now, sck_old, cs_now, cs_old, mosi_now;
    logic sck_rise, sck_fall;
    logic [2:0] rx_bit, rx_idx, tx_bit;
    logic [7:0] rx_sh, tx_hold;
    logic       miso_q;

    // Purpose: bring the asynchronous bus pins into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[SYNC_STAGES-1:0], sck};
            cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sck_now  = sck_p[SYNC_STAGES-1];
    assign sck_old  = sck_p[SYNC_STAGES];
    assign cs_now   = cs_p[SYNC_STAGES-1];
    assign cs_old   = cs_p[SYNC_STAGES];
    assign mosi_now = mosi_p[SYNC_STAGES-1];

    assign sck_rise    = sck_now & ~sck_old & ~cs_now;
    assign sck_fall    = ~sck_now & sck_old & ~cs_now;
    assign frame_start = cs_old & ~cs_now;
    assign frame_end   = ~cs_old & cs_now;

    // Purpose: shift in MOSI and flag each completed byte with its index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit   <= '0;
            rx_idx   <= '0;
            rx_sh    <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
            byte_idx <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (frame_start) begin
                rx_bit <= '0;
                rx_idx <= '0;
            end else if (sck_rise) begin
                rx_sh  <= {rx_sh[6:0], mosi_now};
                rx_bit <= rx_bit + 3'd1;
                if (rx_bit == 3'd7) begin
                    byte_vld <= 1'b1;
                    byte_dat <= {rx_sh[6:0], mosi_now};
                    byte_idx <= rx_idx;
                    if (rx_idx != 3'd7) rx_idx <= rx_idx + 3'd1;
                end
            end
        end
    end

    // Purpose: latch a byte at each byte boundary and shift it out on MISO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit  <= '0;
            tx_hold <= '0;
            miso_q  <= 1'b0;
            tx_next <= 1'b0;
        end else begin
            tx_next <= 1'b0;
            if (frame_start || frame_end) begin
                tx_bit <= '0;
                miso_q <= 1'b0;
            end else if (sck_fall && tx_en) begin
                if (tx_bit == 3'd0) begin
                    tx_hold <= tx_byte;
                    miso_q  <= tx_byte[7];
                end else begin
                    miso_q  <= tx_hold[3'd7 - tx_bit];
                end
                tx_bit <= tx_bit + 3'd1;
                if (tx_bit == 3'd7) tx_next <= 1'b1;
            end
        end
    end

    assign miso = miso_q;
endmodule

// File: rtl/fm_cell_array.sv
// Module: byte array with a pair-capable write port and a combinational
// read port. Writes AND the new data into the old byte, like NOR cells.
// Assumes: DEPTH is a power of two; reset returns every cell to 0xFF.
module fm_cell_array #(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wpair,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wd0,
    input  logic [7:0]    wd1,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdat
);
    logic [7:0]    cells [DEPTH];
    logic [AW-1:0] waddr_nx;

    assign waddr_nx = waddr + AW'(1);

    // Purpose: erase on reset, otherwise clear bits at one or two addresses
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                cells[i] <= 8'hFF;
            end else if (we && waddr == AW'(i)) begin
                cells[i] <= cells[i] & wd0;
            end else if (we && wpair && waddr_nx == AW'(i)) begin
                cells[i] <= cells[i] & wd1;
            end
        end
    end

    assign rdat = cells[raddr];
endmodule

// File: rtl/fm_cmd_ctrl.sv
// Module: command decoder, status register and busy timer. It captures the
// opcode, address and data bytes of a frame, selects the MISO source while
// the frame runs, and commits writes when the frame ends.
// Assumes: byte_vld, tx_next and frame_end never coincide; DEPTH <= 2**24.
module fm_cmd_ctrl
    import flash_model_pkg::*;
#(
    parameter  int DEPTH       = 256,
    parameter  int BUSY_CYCLES = 600,
    localparam int AW          = $clog2(DEPTH),
    localparam int BW          = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_dat,
    input  logic [2:0]    byte_idx,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          tx_next,
    input  logic [7:0]    rd_dat,
    output logic          tx_en,
    output logic [7:0]    tx_byte,
    output logic          wr_en,
    output logic          wr_pair,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_d0,
    output logic [7:0]    wr_d1,
    output logic [AW-1:0] rd_addr,
    output logic [7:0]    status
);
    tx_mode_e      mode_q;
    logic [7:0]    op_q, b1_q, d0_q, d1_q;
    logic [AW-1:0] addr_q, addr_nx, rd_addr_q, ptr_q, even_addr;
    logic [3:0]    nbytes_q;
    logic          busy_at_op_q;
    logic          wel_q, bpl_q, aai_q, arm_q;
    logic [2:0]    bp_q;
    logic [BW-1:0] busy_cnt_q;
    logic          busy, prot;

    assign busy      = (busy_cnt_q != '0);
    assign prot      = |bp_q;
    assign status    = {bpl_q, aai_q, 1'b0, bp_q, wel_q, busy};
    assign addr_nx   = AW'({addr_q, byte_dat});
    assign even_addr = {addr_q[AW-1:1], 1'b0};
    assign tx_en     = (mode_q != TX_IDLE);
    assign tx_byte   = (mode_q == TX_STATUS) ? status : rd_dat;
    assign rd_addr   = rd_addr_q;

    // Purpose: capture frame bytes and steer MISO during the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= TX_IDLE;
            op_q         <= '0;
            b1_q         <= '0;
            d0_q         <= '0;
            d1_q         <= '0;
            addr_q       <= '0;
            rd_addr_q    <= '0;
            nbytes_q     <= '0;
            busy_at_op_q <= 1'b0;
        end else if (frame_start) begin
            mode_q   <= TX_IDLE;
            nbytes_q <= '0;
        end else if (byte_vld) begin
            nbytes_q <= {1'b0, byte_idx} + 4'd1;
            unique case (byte_idx)
                3'd0: begin
                    op_q         <= byte_dat;
                    busy_at_op_q <= busy;
                    if (byte_dat == OP_RDSR) mode_q <= TX_STATUS;
                end
                3'd1: begin
                    addr_q <= addr_nx;
                    b1_q   <= byte_dat;
                    if (aai_q && op_q == OP_BURST) d0_q <= byte_dat;
                end
                3'd2: begin
                    addr_q <= addr_nx;
                    if (aai_q && op_q == OP_BURST) d1_q <= byte_dat;
                end
                3'd3: begin
                    addr_q <= addr_nx;
                    if (op_q == OP_READ && !busy_at_op_q && !aai_q) begin
                        mode_q    <= TX_ARRAY;
                        rd_addr_q <= addr_nx;
                    end
                end
                3'd4: if (!aai_q) d0_q <= byte_dat;
                3'd5: if (!aai_q) d1_q <= byte_dat;
                default: ;
            endcase
        end else if (tx_next && mode_q == TX_ARRAY) begin
            rd_addr_q <= rd_addr_q + AW'(1);
        end
    end

    // Purpose: apply the frame's command at CS_n rise and run the busy timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q      <= 1'b0;
            bpl_q      <= 1'b0;
            aai_q      <= 1'b0;
            arm_q      <= 1'b0;
            bp_q       <= 3'b111;
            ptr_q      <= '0;
            busy_cnt_q <= '0;
            wr_en      <= 1'b0;
            wr_pair    <= 1'b0;
            wr_addr    <= '0;
            wr_d0      <= '0;
            wr_d1      <= '0;
        end else begin
            wr_en <= 1'b0;
            if (busy) busy_cnt_q <= busy_cnt_q - BW'(1);
            if (frame_end && nbytes_q != '0) begin
                arm_q <= (op_q == OP_EWSR) && !busy_at_op_q && !aai_q;
                if (!busy_at_op_q) begin
                    unique case (op_q)
                        OP_WREN: if (!aai_q) wel_q <= 1'b1;
                        OP_WRDI: begin
                            wel_q <= 1'b0;
                            aai_q <= 1'b0;
                        end
                        OP_WRSR: if (arm_q && !aai_q && nbytes_q >= 4'd2) begin
                            bpl_q <= b1_q[ST_BPL];
                            if (!bpl_q) bp_q <= b1_q[4:2];
                        end
                        OP_PROG: if (wel_q && !aai_q && !prot && nbytes_q >= 4'd5) begin
                            wr_en      <= 1'b1;
                            wr_pair    <= 1'b0;
                            wr_addr    <= addr_q;
                            wr_d0      <= d0_q;
                            wel_q      <= 1'b0;
                            busy_cnt_q <= BW'(BUSY_CYCLES);
                        end
                        OP_BURST: begin
                            if (!aai_q && wel_q && !prot && nbytes_q >= 4'd6) begin
                                wr_en      <= 1'b1;
                                wr_pair    <= 1'b1;
                                wr_addr    <= even_addr;
                                wr_d0      <= d0_q;
                                wr_d1      <= d1_q;
                                aai_q      <= 1'b1;
                                ptr_q      <= even_addr + AW'(2);
                                busy_cnt_q <= BW'(BUSY_CYCLES);
                            end else if (aai_q && wel_q && !prot && nbytes_q >= 4'd3) begin
                                wr_en      <= 1'b1;
                                wr_pair    <= 1'b1;
                                wr_addr    <= ptr_q;
                                wr_d0      <= d0_q;
                                wr_d1      <= d1_q;
                                ptr_q      <= ptr_q + AW'(2);
                                busy_cnt_q <= BW'(BUSY_CYCLES);
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/flash_model.sv
// Module: top of the SPI serial NOR flash model. It joins the bus front
// end, the command controller and the byte array.
// Assumes: mode-0 bus; SCK well below clk/2*(SYNC_STAGES+2).
module flash_model #(
    parameter int DEPTH       = 256,
    parameter int BUSY_CYCLES = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int AW = $clog2(DEPTH);

    logic          byte_vld, frame_start, frame_end, tx_next, tx_en;
    logic [7:0]    byte_dat, tx_byte, rd_dat, wr_d0, wr_d1, status_byte;
    logic [2:0]    byte_idx;
    logic          wr_en, wr_pair;
    logic [AW-1:0] wr_addr, rd_addr;

    fm_spi_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_en(tx_en), .tx_byte(tx_byte), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .byte_idx(byte_idx), .frame_start(frame_start),
        .frame_end(frame_end), .tx_next(tx_next), .miso(miso)
    );

    fm_cmd_ctrl #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .byte_idx(byte_idx), .frame_start(frame_start), .frame_end(frame_end),
        .tx_next(tx_next), .rd_dat(rd_dat), .tx_en(tx_en), .tx_byte(tx_byte),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_addr(wr_addr), .wr_d0(wr_d0),
        .wr_d1(wr_d1), .rd_addr(rd_addr), .status(status_byte)
    );

    fm_cell_array #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .wpair(wr_pair),
        .waddr(wr_addr), .wd0(wr_d0), .wd1(wr_d1), .raddr(rd_addr),
        .rdat(rd_dat)
    );
endmodule

// File: rtl/fm_checker.sv
// Module: property checker for flash_model, bound to every instance.
// Assumes: SYNC_STAGES = 2 for the MISO idle window.
module fm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input logic       wr_en,
    input logic [7:0] status
);
    // R1
    rst_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> status == 8'h1C);

    // R2
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // R6
    wr_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(status[4:2]) == 3'b000);

    // R7
    wr_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(status[1]));

    // R10
    wr_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[0]);

    // R10
    wr_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(status[0]));

    // R8
    burst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> wr_en);
endmodule

bind flash_model fm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
    .wr_en(wr_en), .status(status_byte)
);

// File: tb/sim_flash_model.sv
// Bench: table-driven status sequences, then directed array and corner tests.
module sim_flash_model;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    localparam int HALF = 6;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] tx [8];
    logic [7:0] rx [8];
    logic [7:0] st;

    always #10 clk = ~clk;

    flash_model #(.DEPTH(256), .BUSY_CYCLES(600), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    // Entry: {req[29:26], check[25], two_bytes[24], op[23:16], data[15:8], expected status[7:0]}
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {4'd3,  1'b1, 1'b0, 8'h06, 8'h00, 8'h1E},  // R3 WREN
        {4'd3,  1'b1, 1'b0, 8'h04, 8'h00, 8'h1C},  // R3 WRDI
        {4'd4,  1'b1, 1'b1, 8'h01, 8'h00, 8'h1C},  // R4 not armed
        {4'd4,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00},
        {4'd4,  1'b1, 1'b1, 8'h01, 8'h8C, 8'h8C},  // R4 armed write
        {4'd5,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00},
        {4'd5,  1'b1, 1'b1, 8'h01, 8'h80, 8'h8C},  // R5 protect field locked
        {4'd5,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00},
        {4'd5,  1'b1, 1'b1, 8'h01, 8'h00, 8'h0C},  // R5 old lock still guards
        {4'd4,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00},
        {4'd4,  1'b0, 1'b0, 8'h06, 8'h00, 8'h00},
        {4'd4,  1'b1, 1'b1, 8'h01, 8'h00, 8'h0E},  // R4 intervening frame
        {4'd4,  1'b0, 1'b0, 8'h50, 8'h00, 8'h00},
        {4'd4,  1'b1, 1'b1, 8'h01, 8'h00, 8'h02},
        {4'd12, 1'b1, 1'b0, 8'h20, 8'h00, 8'h02},  // R12 erase no-op
        {4'd12, 1'b1, 1'b0, 8'h9F, 8'h00, 8'h02},  // R12 undefined opcode
        {4'd3,  1'b1, 1'b0, 8'h04, 8'h00, 8'h00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int n);
        cs_n = 1'b0;
        tick(HALF);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx[b][i];
                tick(HALF);
                sck = 1'b1;
                rx[b][i] = miso;
                tick(HALF);
                sck = 1'b0;
            end
        end
        tick(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        tick(8);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic op1(input logic [7:0] op);
        tx[0] = op;
        frame(1);
    endtask

    task automatic rdsr(output logic [7:0] s);
        tx[0] = 8'h05;
        tx[1] = 8'h00;
        frame(2);
        s = rx[1];
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 20 && s[0]; k++) rdsr(s);
        check("R10 busy clears", {7'd0, s[0]}, 8'h00);
    endtask

    task automatic prog(input logic [23:0] a, input logic [7:0] d);
        tx[0] = 8'h02; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0]; tx[4] = d;
        frame(5);
    endtask

    task automatic rdmem(input logic [23:0] a, input int n);
        tx[0] = 8'h03; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
        for (int j = 0; j < n; j++) tx[4 + j] = 8'h00;
        frame(4 + n);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        check("R1 miso low", {7'd0, miso}, 8'h00);
        rdsr(st);
        check("R1 status", st, 8'h1C);
        rdmem(24'h000000, 1);
        check("R1 erased", rx[4], 8'hFF);

        // R6 protected array refuses programming, WEL kept
        op1(8'h06);
        prog(24'h000005, 8'h00);
        rdsr(st);
        check("R6 status", st, 8'h1E);
        rdmem(24'h000005, 1);
        check("R6 array", rx[4], 8'hFF);
        op1(8'h04);

        // Status register sequences from the table
        for (int v = 0; v < NV; v++) begin
            tx[0] = VEC[v][23:16];
            tx[1] = VEC[v][15:8];
            frame(VEC[v][24] ? 2 : 1);
            if (VEC[v][25]) begin
                rdsr(st);
                check($sformatf("R%0d table entry %0d", VEC[v][29:26], v), st, VEC[v][7:0]);
            end
        end

        // R7 program needs WEL
        prog(24'h000010, 8'h00);
        rdmem(24'h000010, 1);
        check("R7 no WEL", rx[4], 8'hFF);
        op1(8'h06);
        prog(24'h000010, 8'hA5);
        rdsr(st);
        check("R10 busy, R7 WEL cleared", st, 8'h01);
        op1(8'h06);
        wait_ready();
        rdsr(st);
        check("R10 WREN ignored while busy", st, 8'h00);
        rdmem(24'h000010, 1);
        check("R7 first program", rx[4], 8'hA5);
        op1(8'h06);
        prog(24'h000010, 8'h3C);
        wait_ready();
        rdmem(24'h000010, 1);
        check("R7 AND semantics", rx[4], 8'h24);

        // R8 burst start at odd address
        op1(8'h06);
        tx[0] = 8'hAD; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h21; tx[4] = 8'h11; tx[5] = 8'h22;
        frame(6);
        rdsr(st);
        check("R8 burst status busy", st, 8'h43);
        wait_ready();
        // R2 repeated status while CS_n stays low
        tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00;
        frame(4);
        check("R2 status byte 1", rx[1], 8'h42);
        check("R2 status byte 2", rx[2], 8'h42);
        check("R2 status byte 3", rx[3], 8'h42);

        // R11 other commands ignored in burst mode
        prog(24'h000030, 8'h00);
        rdmem(24'h000020, 1);
        check("R11 read blocked", rx[4], 8'h00);

        // R9 continuation frame
        tx[0] = 8'hAD; tx[1] = 8'h33; tx[2] = 8'h44;
        frame(3);
        rdsr(st);
        check("R9 continuation busy", st, 8'h43);
        wait_ready();
        op1(8'h04);
        rdsr(st);
        check("R3 WRDI leaves burst", st, 8'h00);
        rdmem(24'h000020, 4);
        check("R8 even byte", rx[4], 8'h11);
        check("R8 odd byte", rx[5], 8'h22);
        check("R9 next even", rx[6], 8'h33);
        check("R9 next odd", rx[7], 8'h44);
        rdmem(24'h000030, 1);
        check("R11 program blocked", rx[4], 8'hFF);

        // R13 wrap and high address bits
        op1(8'h06);
        prog(24'h000000, 8'h5A);
        wait_ready();
        rdmem(24'h0000FF, 2);
        check("R13 top byte", rx[4], 8'hFF);
        check("R13 wrap", rx[5], 8'h5A);
        rdmem(24'h010000, 1);
        check("R13 alias", rx[4], 8'h5A);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule